// File: doc/BRIEF.md
# STS-3c Transmit Section Overhead Inserter

This block assembles a concatenated three-channel SONET transmit frame, one byte per octet clock. A frame is 9 rows of 270 byte columns; the first nine columns of each row are overhead, interleaved as three STS-1 channels, and every other column is payload taken from an upstream byte source over a ready/valid handshake. The block fills the section overhead (framing, trace and growth, B1 parity, data link bytes) and the S1 synchronization status byte, scrambles the stream with the frame-synchronous scrambler, and can force the whole output to zero for line testing.

Each overhead field has its own static control input, so a configuration block (not part of this design) can override framing, trace, parity and data link content independently. A reference output gives either a once-per-frame pulse of selectable polarity or the octet clock itself, for use by downstream framing or test equipment.

Top module: `sts3c_oh_tx`

## Requirements
- R1: In row 1, columns 1-3 carry 0xF6 and columns 4-6 carry 0x28 when `cfg_a1a2_off` is 0, and 0x00 when it is 1; all nine row-1 overhead bytes leave unscrambled.
- R2: Row 1 column 7 carries 0x01 when `cfg_trace_en` is 0 and `trace_byte` when it is 1.
- R3: Row 1 columns 8 and 9 always carry 0x02 and 0x03.
- R4: Row 2 column 1 carries, before scrambling, the XOR of every scrambled (pre-zero-force) byte of the previous whole frame; it is 0x00 for the first frame after reset and 0x00 whenever `cfg_b1_off` is 1.
- R5: Row 3 columns 1, 4 and 7 carry `dl_byte1`, `dl_byte2`, `dl_byte3` when `cfg_dl_en` is 1, and 0x00 otherwise.
- R6: Row 9 column 1 carries `s1_code` (bit 7 transmitted first); every other overhead position not named in R1-R5 carries 0x00 before scrambling.
- R7: Every byte outside row 1 columns 1-9 is XORed with the x^7+x^6+1 sequence, generated MSB first from a state loaded with all ones at row 1 column 10 (first key byte 0xFE); `cfg_scr_off` = 1 sends the bytes unscrambled.
- R8: With `cfg_zero_ins` = 1 the output byte is 0x00 regardless of position.
- R9: `in_ready` is 1 exactly in payload columns (10-270); there a byte is taken from `in_data` if `in_valid` is 1, else 0x00 is sent.
- R10: With `cfg_fref_clk` = 0, `fref_out` is at its active level (high when `cfg_fref_pol` = 1, low when 0) for exactly the one octet in which the first row-1 byte is on `tx_byte`, once every 2430 octets.
- R11: With `cfg_fref_clk` = 1, `fref_out` follows `clk`.
- R12: `tx_byte` is registered: the byte for a position appears one clock after that position is current; during reset it is 0x00, the frame pulse is inactive and the frame restarts at row 1 column 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Octet clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | Payload byte present |
| in_ready | output | 1 | Current position is a payload column |
| cfg_scr_off | input | 1 | Bypass the scrambler |
| cfg_dl_en | input | 1 | Send data link bytes |
| cfg_trace_en | input | 1 | Send programmable trace byte |
| cfg_a1a2_off | input | 1 | Force framing bytes to zero |
| cfg_b1_off | input | 1 | Force B1 to zero |
| cfg_zero_ins | input | 1 | Force all output bytes to zero |
| cfg_fref_clk | input | 1 | Reference output selects octet clock |
| cfg_fref_pol | input | 1 | Frame pulse active high when 1 |
| trace_byte | input | 8 | Section trace value |
| dl_byte1 | input | 8 | First data link byte |
| dl_byte2 | input | 8 | Second data link byte |
| dl_byte3 | input | 8 | Third data link byte |
| s1_code | input | 8 | Synchronization status value |
| tx_byte | output | 8 | Transmit byte |
| fref_out | output | 1 | Frame pulse or octet clock |

## Verification
Every output byte is due exactly one clock after its position is current and its inputs (payload, controls) are presented, while `in_ready` is valid in the same cycle as the position. The bench drives inputs just after the falling edge, so the next rising edge captures them, and compares `tx_byte` and `fref_out` at the following falling edge against a model advanced once per cycle. The B1 result is due one full frame later, which the model reproduces by carrying its parity accumulator across frame boundaries rather than predicting B1 in isolation.

// File: rtl/sts3c_tx_pkg.sv
package sts3c_tx_pkg;
   localparam int unsigned FRAME_ROWS = 9;
   localparam logic [7:0] FRAMING_HI = 8'hF6;
   localparam logic [7:0] FRAMING_LO = 8'h28;
   localparam logic [7:0] TRACE_IDLE = 8'h01;
   localparam logic [6:0] SCR_SEED   = 7'h7F;

   typedef struct packed {
      logic       dl_en;
      logic       trace_en;
      logic       a1a2_off;
      logic       b1_off;
      logic [7:0] trace;
      logic [7:0] dl1;
      logic [7:0] dl2;
      logic [7:0] dl3;
      logic [7:0] s1;
   } oh_cfg_t;
endpackage

// File: rtl/sts3c_frame_ctr.sv
module sts3c_frame_ctr #(
   parameter int ROWS = 9,
   parameter int COLS = 270,
   localparam int RW = $clog2(ROWS),
   localparam int CW = $clog2(COLS)
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [RW-1:0] row_q,
   output logic [CW-1:0] col_q
);
   localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);
   localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_q <= '0;
         col_q <= '0;
      end else if (col_q == LAST_COL) begin
         col_q <= '0;
         row_q <= (row_q == LAST_ROW) ? '0 : row_q + 1'b1;
      end else begin
         col_q <= col_q + 1'b1;
      end
   end
endmodule

// File: rtl/sts3c_oh_sel.sv
module sts3c_oh_sel
   import sts3c_tx_pkg::*;
#(
   parameter int NUM_STS = 3,
   parameter int COLS    = 270,
   localparam int RW     = $clog2(FRAME_ROWS),
   localparam int CW     = $clog2(COLS),
   localparam int OH_COLS = 3 * NUM_STS
) (
   input  logic [RW-1:0] row,
   input  logic [CW-1:0] col,
   input  oh_cfg_t       cfg,
   input  logic [7:0]    b1_val,
   input  logic [7:0]    in_data,
   input  logic          in_valid,
   output logic [7:0]    pre_byte,
   output logic          is_payload
);
   int oh_col;
   int sts;

   always_comb begin
      oh_col     = int'(col) / NUM_STS;
      sts        = int'(col) % NUM_STS;
      is_payload = (int'(col) >= OH_COLS);
      pre_byte   = 8'h00;
      if (is_payload) begin
         pre_byte = in_valid ? in_data : 8'h00;
      end else begin
         case (int'(row))
            0: begin
               case (oh_col)
                  0: pre_byte = cfg.a1a2_off ? 8'h00 : FRAMING_HI;
                  1: pre_byte = cfg.a1a2_off ? 8'h00 : FRAMING_LO;
                  default: begin
                     if (sts == 0) pre_byte = cfg.trace_en ? cfg.trace : TRACE_IDLE;
                     else          pre_byte = 8'(sts + 1);
                  end
               endcase
            end
            1: if (col == '0) pre_byte = cfg.b1_off ? 8'h00 : b1_val;
            2: begin
               if (sts == 0 && cfg.dl_en) begin
                  case (oh_col)
                     0:       pre_byte = cfg.dl1;
                     1:       pre_byte = cfg.dl2;
                     default: pre_byte = cfg.dl3;
                  endcase
               end
            end
            8: if (col == '0) pre_byte = cfg.s1;
            default: pre_byte = 8'h00;
         endcase
      end
   end
endmodule

// File: rtl/sts3c_frame_scr.sv
module sts3c_frame_scr
   import sts3c_tx_pkg::*;
#(
   parameter int BITS = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic            adv,
   output logic [BITS-1:0] key
);
   logic [6:0] state_q;
   logic [6:0] walk [BITS+1];

   assign walk[0] = load ? SCR_SEED : state_q;

   for (genvar i = 0; i < BITS; i++) begin : g_step
      assign key[BITS-1-i] = walk[i][6];
      assign walk[i+1]     = {walk[i][5:0], walk[i][6] ^ walk[i][5]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   state_q <= SCR_SEED;
      else if (adv) state_q <= walk[BITS];
   end
endmodule

// File: rtl/sts3c_bip8.sv
module sts3c_bip8 #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         frame_start,
   input  logic [W-1:0] byte_in,
   output logic [W-1:0] parity_q
);
   logic [W-1:0] acc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q    <= '0;
         parity_q <= '0;
      end else if (frame_start) begin
         parity_q <= acc_q;
         acc_q    <= byte_in;
      end else begin
         acc_q    <= acc_q ^ byte_in;
      end
   end
endmodule

// File: rtl/sts3c_oh_tx.sv
module sts3c_oh_tx
   import sts3c_tx_pkg::*;
#(
   parameter int NUM_STS      = 3,
   parameter int COLS_PER_STS = 90
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] in_data,
   input  logic       in_valid,
   output logic       in_ready,
   input  logic       cfg_scr_off,
   input  logic       cfg_dl_en,
   input  logic       cfg_trace_en,
   input  logic       cfg_a1a2_off,
   input  logic       cfg_b1_off,
   input  logic       cfg_zero_ins,
   input  logic       cfg_fref_clk,
   input  logic       cfg_fref_pol,
   input  logic [7:0] trace_byte,
   input  logic [7:0] dl_byte1,
   input  logic [7:0] dl_byte2,
   input  logic [7:0] dl_byte3,
   input  logic [7:0] s1_code,
   output logic [7:0] tx_byte,
   output logic       fref_out
);
   localparam int COLS    = NUM_STS * COLS_PER_STS;
   localparam int OH_COLS = 3 * NUM_STS;
   localparam int RW      = $clog2(FRAME_ROWS);
   localparam int CW      = $clog2(COLS);

   if (NUM_STS < 1 || NUM_STS > 250) begin : g_bad_sts
      $error("NUM_STS out of range");
   end
   if (COLS_PER_STS <= 3) begin : g_bad_cols
      $error("COLS_PER_STS must exceed the overhead width");
   end

   logic [RW-1:0] row_q;
   logic [CW-1:0] col_q;
   logic          sof, row0_oh, scr_load;
   logic [7:0]    pre_byte, key, line_byte, b1_val;
   logic          is_payload;
   logic [7:0]    tx_q;
   logic          pulse_q;
   oh_cfg_t       cfg;

   assign cfg = '{dl_en: cfg_dl_en, trace_en: cfg_trace_en, a1a2_off: cfg_a1a2_off,
                  b1_off: cfg_b1_off, trace: trace_byte, dl1: dl_byte1,
                  dl2: dl_byte2, dl3: dl_byte3, s1: s1_code};

   sts3c_frame_ctr #(.ROWS(FRAME_ROWS), .COLS(COLS)) u_ctr (
      .clk(clk), .rst_n(rst_n), .row_q(row_q), .col_q(col_q)
   );

   assign sof      = (row_q == '0) && (col_q == '0);
   assign row0_oh  = (row_q == '0) && (int'(col_q) < OH_COLS);
   assign scr_load = (row_q == '0) && (int'(col_q) == OH_COLS);

   sts3c_oh_sel #(.NUM_STS(NUM_STS), .COLS(COLS)) u_sel (
      .row(row_q), .col(col_q), .cfg(cfg), .b1_val(b1_val),
      .in_data(in_data), .in_valid(in_valid),
      .pre_byte(pre_byte), .is_payload(is_payload)
   );

   sts3c_frame_scr #(.BITS(8)) u_scr (
      .clk(clk), .rst_n(rst_n), .load(scr_load), .adv(!row0_oh), .key(key)
   );

   assign line_byte = (row0_oh || cfg_scr_off) ? pre_byte : (pre_byte ^ key);

   sts3c_bip8 #(.W(8)) u_bip (
      .clk(clk), .rst_n(rst_n), .frame_start(sof), .byte_in(line_byte), .parity_q(b1_val)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_q    <= 8'h00;
         pulse_q <= 1'b0;
      end else begin
         tx_q    <= cfg_zero_ins ? 8'h00 : line_byte;
         pulse_q <= sof;
      end
   end

   assign in_ready = is_payload;
   assign tx_byte  = tx_q;
   assign fref_out = cfg_fref_clk ? clk : (cfg_fref_pol ? pulse_q : !pulse_q);
endmodule

// File: rtl/sts3c_oh_tx_chk.sv
module sts3c_oh_tx_chk #(
   parameter int NUM_STS      = 3,
   parameter int COLS_PER_STS = 90,
   localparam int COLS    = NUM_STS * COLS_PER_STS,
   localparam int OH_COLS = 3 * NUM_STS,
   localparam int RW      = $clog2(9),
   localparam int CW      = $clog2(COLS)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_ready,
   input logic [7:0]    tx_byte,
   input logic          fref_out,
   input logic          cfg_zero_ins,
   input logic          cfg_a1a2_off,
   input logic          cfg_fref_clk,
   input logic          cfg_fref_pol,
   input logic [RW-1:0] row_q,
   input logic [CW-1:0] col_q
);
   logic at_sof;
   assign at_sof = (row_q == '0) && (col_q == '0);

   p_a1_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (at_sof && !cfg_a1a2_off && !cfg_zero_ins) |=> (tx_byte == 8'hF6));

   p_z0_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (NUM_STS > 1 && row_q == '0 && int'(col_q) == 2 * NUM_STS + 1 && !cfg_zero_ins)
      |=> (tx_byte == 8'h02));

   p_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_zero_ins |=> (tx_byte == 8'h00));

   p_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> (int'(col_q) >= OH_COLS));

   p_pulse_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
      at_sof |=> (cfg_fref_clk || fref_out == cfg_fref_pol));

   p_pulse_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !at_sof |=> (cfg_fref_clk || fref_out != cfg_fref_pol));

   p_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(row_q) == 8 && int'(col_q) == COLS - 1) |=> at_sof);
endmodule

bind sts3c_oh_tx sts3c_oh_tx_chk #(.NUM_STS(NUM_STS), .COLS_PER_STS(COLS_PER_STS)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .tx_byte(tx_byte), .fref_out(fref_out),
   .cfg_zero_ins(cfg_zero_ins), .cfg_a1a2_off(cfg_a1a2_off), .cfg_fref_clk(cfg_fref_clk),
   .cfg_fref_pol(cfg_fref_pol), .row_q(row_q), .col_q(col_q)
);

// File: tb/sts3c_oh_tx_test.sv
`timescale 1ns/1ps
module sts3c_oh_tx_test;
   localparam int NCOL  = 270;
   localparam int FRAME = 9 * NCOL;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic in_valid = 1'b0;
   logic in_ready;
   logic cfg_scr_off = 0, cfg_dl_en = 0, cfg_trace_en = 0, cfg_a1a2_off = 0;
   logic cfg_b1_off = 0, cfg_zero_ins = 0, cfg_fref_clk = 0, cfg_fref_pol = 0;
   logic [7:0] trace_byte = 8'h00, dl_byte1 = 8'h00, dl_byte2 = 8'h00;
   logic [7:0] dl_byte3 = 8'h00, s1_code = 8'h00;
   logic [7:0] tx_byte;
   logic fref_out;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #4 clk = ~clk;

   sts3c_oh_tx uut (.*);

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic string tag_of(input int r, input int c);
      if (r == 0 && c < 6)  return "R1";
      if (r == 0 && c == 6) return "R2";
      if (r == 0 && c < 9)  return "R3";
      if (r == 1 && c == 0) return "R4";
      if (r == 2 && (c == 0 || c == 3 || c == 6)) return "R5";
      if (c < 9) return "R6";
      return "R9";
   endfunction

   // reference model state
   int r = 0, c = 0;
   logic [6:0] s = 7'h7F;
   logic [7:0] acc = 0, hold = 0;
   logic [7:0] exp_byte;
   logic exp_pulse;
   string exp_tag;

   task automatic model_step();
      logic [7:0] pre, post, ks;
      bit payload;
      payload = (c >= 9);
      if (r == 0 && c == 0) begin hold = acc; acc = 0; end
      pre = 8'h00;
      if (payload) pre = in_valid ? in_data : 8'h00;
      else if (r == 0 && c < 3) pre = cfg_a1a2_off ? 8'h00 : 8'hF6;
      else if (r == 0 && c < 6) pre = cfg_a1a2_off ? 8'h00 : 8'h28;
      else if (r == 0 && c == 6) pre = cfg_trace_en ? trace_byte : 8'h01;
      else if (r == 0) pre = (c == 7) ? 8'h02 : 8'h03;
      else if (r == 1 && c == 0) pre = cfg_b1_off ? 8'h00 : hold;
      else if (r == 2 && cfg_dl_en && c == 0) pre = dl_byte1;
      else if (r == 2 && cfg_dl_en && c == 3) pre = dl_byte2;
      else if (r == 2 && cfg_dl_en && c == 6) pre = dl_byte3;
      else if (r == 8 && c == 0) pre = s1_code;
      exp_tag = tag_of(r, c);
      if (r == 0 && c < 9) post = pre;
      else begin
         if (r == 0 && c == 9) s = 7'h7F;
         for (int i = 7; i >= 0; i--) begin
            ks[i] = s[6];
            s = {s[5:0], s[6] ^ s[5]};
         end
         post = cfg_scr_off ? pre : pre ^ ks;
         if (!cfg_scr_off) exp_tag = {exp_tag, "/R7"};
      end
      acc ^= post;
      exp_byte  = cfg_zero_ins ? 8'h00 : post;
      if (cfg_zero_ins) exp_tag = {exp_tag, "/R8"};
      exp_pulse = (r == 0 && c == 0);
      c++;
      if (c == NCOL) begin c = 0; r = (r == 8) ? 0 : r + 1; end
   endtask

   initial begin
      int cyc;
      repeat (3) @(negedge clk);
      check("R12 reset tx_byte", tx_byte, 0);
      check("R12 reset pulse inactive", fref_out, 1);
      check("R12 reset ready low", in_ready, 0);
      rst_n = 1'b1;
      model_step();
      cyc = 1;
      while (cyc < 6 * FRAME + 20) begin
         @(negedge clk);
         // results of the previous position, registered one edge ago
         check({exp_tag, " tx_byte"}, tx_byte, exp_byte);
         if (cfg_fref_clk) check("R11 fref follows clk", fref_out, clk);
         else check("R10 fref pulse", fref_out, exp_pulse ? cfg_fref_pol : !cfg_fref_pol);
         check("R9 in_ready", in_ready, (c >= 9));
         if (cyc == FRAME + 3) begin
            cfg_trace_en = 1; trace_byte = 8'h5A; cfg_dl_en = 1;
            dl_byte1 = 8'h11; dl_byte2 = 8'h22; dl_byte3 = 8'h33;
            s1_code = 8'hA5; cfg_fref_pol = 1;
         end
         if (cyc == 2 * FRAME + 7) begin cfg_a1a2_off = 1; cfg_b1_off = 1; cfg_scr_off = 1; end
         if (cyc == 3 * FRAME + 1) begin
            cfg_a1a2_off = 0; cfg_b1_off = 0; cfg_scr_off = 0; cfg_fref_clk = 1;
         end
         if (cyc == 3 * FRAME + 100) cfg_zero_ins = 1;
         if (cyc == 3 * FRAME + 400) cfg_zero_ins = 0;
         if (cyc == 4 * FRAME) begin cfg_fref_clk = 0; cfg_trace_en = 0; cfg_dl_en = 0; end
         in_valid = (($urandom % 4) != 0);
         in_data  = 8'($urandom);
         model_step();
         cyc++;
      end
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         done = 1;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule